// File: doc/BRIEF.md
# Adaptive Context Probability Estimator

This block keeps the adaptive probability state of a binary arithmetic coder for a fixed set of coding contexts. Each context carries a probability-state index (0 to 46) and the value of its more-probable symbol (MPS). A request gives a context label and the decision being coded. One cycle later the block returns that context's current index, its MPS bit, the 16-bit probability of the less-probable symbol (LPS), and the count of leading zeros of that probability. The block then writes the context's updated state back.

The state transitions are not held in tables. The next index after an MPS, the next index after an LPS, and the MPS-inversion flag are computed from the index by piecewise arithmetic rules. The probability values sit in a de-duplicated store of 32 distinct 13-bit entries. Each full 16-bit value is rebuilt from its entry by adding a zero on top and binary 01 below. A request that names the context written back in the same cycle sees the freshly updated state, so a run of requests on one context can be issued back to back.

Top module: `ctx_prob_estimator`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and sets every context to index 0 with MPS bit 0. The first request to any context after reset returns index 0, MPS 0, probability 0x5601 and leading-zero count 1.
- R2: A request with `in_valid` high and `in_ctx` below 19, sampled at one rising edge, gives `out_valid` high for exactly the next cycle. When no such request is sampled, `out_valid` is low.
- R3: `out_qe` is the LPS probability of the returned index, taken from the standard 47-entry probability list. Bit 15 is always 0 and bits 1:0 are always 01.
- R4: `out_lz` equals the number of zero bits above the most significant 1 of the 16-bit `out_qe`.
- R5: A decision equal to the context's MPS bit is an MPS. After it, the index becomes x+1 for x in 0..4, 6..12 and 14..44. It becomes 38 from 5, 29 from 13, and stays unchanged at 45 and 46. The MPS bit is unchanged.
- R6: A decision different from the MPS bit is an LPS. After it, the index becomes 1 from 0 and 3(x+1) for x in 1..3. It becomes 29 from 4 and 33 from 5. It stays unchanged at 6 and 46. It becomes 14 for x in 7..9 and 14..15, x+7 for x in 10..11, x+8 for x in 12..13, x-1 for x in 16..20, and x-2 for x in 21..45.
- R7: An LPS coded at index 0, 6 or 14 inverts the context's MPS bit. An LPS at any other index leaves the MPS bit unchanged.
- R8: A request on the context that was requested in the previous cycle returns the state that the previous request produced.
- R9: A request changes only the state of its own context. All other contexts keep their state.
- R10: A request with `in_ctx` of 19 or more, or with `in_valid` low, is ignored. `out_valid` stays low in the next cycle and no context state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_ctx | input | CTX_W (5) | Context label, 0..NUM_CTX-1 |
| in_dec | input | 1 | Decision bit being coded |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_idx | output | 6 | Probability-state index of the context before the update |
| out_mps | output | 1 | MPS bit of the context before the update |
| out_qe | output | 16 | LPS probability for `out_idx` |
| out_lz | output | 4 | Leading-zero count of `out_qe` |

## Verification
The bound checker watches several rules on every cycle:
- the one-cycle valid timing and the rejection of out-of-range labels;
- the fixed top and bottom bits of every probability;
- the agreement of the leading-zero count with the probability it accompanies;
- on back-to-back requests to one context, that an MPS never lowers the index or changes the MPS bit, and that an LPS inverts the MPS bit exactly at indices 0, 6 and 14.

Some behaviour only the bench scenarios can show: the exact next index after every transition, the probability value of each index, forwarding over long same-context bursts, and isolation between contexts. For these the bench runs long pseudo-random request streams with two different MPS/LPS mixes against an arithmetic model, then reads every context back.

// File: rtl/ctxprob_pkg.sv
package ctxprob_pkg;
  localparam int IDX_W    = 6;
  localparam int NUM_IDX  = 47;
  localparam int SLOT_W   = 5;
  localparam int NUM_SLOT = 32;
  localparam int QE_W     = 16;
  localparam int QSTORE_W = QE_W - 3;
  localparam int LZ_W     = 4;

  typedef logic [IDX_W-1:0] idx_t;

  // index in the upper bits, MPS bit in the LSB
  typedef struct packed {
    idx_t idx;
    logic mps;
  } ctx_state_t;

  typedef struct packed {
    logic [QE_W-1:0] qe;
    logic [LZ_W-1:0] lz;
  } prob_t;

  // Stored part of each distinct probability: bits 14..2 of the full value.
  function automatic logic [QSTORE_W-1:0] slot_value(input logic [SLOT_W-1:0] s);
    logic [QE_W-1:0] v;
    case (s)
      5'd0:  v = 16'h5601;  5'd1:  v = 16'h5401;  5'd2:  v = 16'h5101;
      5'd3:  v = 16'h4801;  5'd4:  v = 16'h3801;  5'd5:  v = 16'h3401;
      5'd6:  v = 16'h3001;  5'd7:  v = 16'h2801;  5'd8:  v = 16'h2401;
      5'd9:  v = 16'h2201;  5'd10: v = 16'h1c01;  5'd11: v = 16'h1801;
      5'd12: v = 16'h1601;  5'd13: v = 16'h1401;  5'd14: v = 16'h1201;
      5'd15: v = 16'h1101;  5'd16: v = 16'h0ac1;  5'd17: v = 16'h09c1;
      5'd18: v = 16'h08a1;  5'd19: v = 16'h0521;  5'd20: v = 16'h0441;
      5'd21: v = 16'h02a1;  5'd22: v = 16'h0221;  5'd23: v = 16'h0141;
      5'd24: v = 16'h0111;  5'd25: v = 16'h0085;  5'd26: v = 16'h0049;
      5'd27: v = 16'h0025;  5'd28: v = 16'h0015;  5'd29: v = 16'h0009;
      5'd30: v = 16'h0005;  default: v = 16'h0001;
    endcase
    return v[QE_W-2:2];
  endfunction

  function automatic int lead_zeros(input logic [QE_W-1:0] v);
    int n;
    n = QE_W;
    for (int b = 0; b < QE_W; b++) begin
      if (v[b]) n = QE_W - 1 - b;
    end
    return n;
  endfunction

  // Index to distinct-value slot: 14..45 is a plain offset, the rest is irregular.
  function automatic logic [SLOT_W-1:0] index_to_slot(input idx_t x);
    logic [SLOT_W-1:0] s;
    if (x >= 6'd14 && x <= 6'd45) begin
      s = SLOT_W'(x - 6'd14);
    end else begin
      case (x)
        6'd1:  s = 5'd5;
        6'd2:  s = 5'd11;
        6'd3:  s = 5'd16;
        6'd4:  s = 5'd19;
        6'd5:  s = 5'd22;
        6'd7:  s = 5'd1;
        6'd8:  s = 5'd3;
        6'd9:  s = 5'd4;
        6'd10: s = 5'd6;
        6'd11: s = 5'd8;
        6'd12: s = 5'd10;
        6'd13: s = 5'd12;
        default: s = 5'd0;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/cp_next_state.sv
module cp_next_state
  import ctxprob_pkg::*;
(
  input  ctx_state_t cur,
  input  logic       dec,
  output ctx_state_t nxt
);
  idx_t x;
  idx_t after_mps;
  idx_t after_lps;
  logic flip;
  logic is_mps;

  always_comb begin
    x = cur.idx;

    if (x == 6'd5)       after_mps = 6'd38;
    else if (x == 6'd13) after_mps = 6'd29;
    else if (x >= 6'd45) after_mps = x;
    else                 after_mps = x + 6'd1;

    if (x == 6'd0)                    after_lps = 6'd1;
    else if (x <= 6'd3)               after_lps = (x << 1) + x + 6'd3;
    else if (x == 6'd4)               after_lps = 6'd29;
    else if (x == 6'd5)               after_lps = 6'd33;
    else if (x == 6'd6 || x == 6'd46) after_lps = x;
    else if (x <= 6'd9)               after_lps = 6'd14;
    else if (x <= 6'd11)              after_lps = x + 6'd7;
    else if (x <= 6'd13)              after_lps = x + 6'd8;
    else if (x <= 6'd15)              after_lps = 6'd14;
    else if (x <= 6'd20)              after_lps = x - 6'd1;
    else                              after_lps = x - 6'd2;

    flip   = (x == 6'd0) || (x == 6'd6) || (x == 6'd14);
    is_mps = (dec == cur.mps);

    nxt.idx = is_mps ? after_mps : after_lps;
    nxt.mps = (!is_mps && flip) ? ~cur.mps : cur.mps;
  end
endmodule

// File: rtl/cp_prob_lookup.sv
module cp_prob_lookup
  import ctxprob_pkg::*;
(
  input  idx_t  idx,
  output prob_t prob
);
  logic [QE_W-1:0]   qe_tab [NUM_SLOT];
  logic [LZ_W-1:0]   lz_tab [NUM_SLOT];
  logic [SLOT_W-1:0] slot;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    localparam logic [QE_W-1:0] QV = {1'b0, slot_value(SLOT_W'(g)), 2'b01};
    localparam int LZ = lead_zeros(QV);
    assign qe_tab[g] = QV;
    assign lz_tab[g] = LZ_W'(LZ);
  end

  always_comb slot = index_to_slot(idx);

  assign prob.qe = qe_tab[slot];
  assign prob.lz = lz_tab[slot];
endmodule

// File: rtl/cp_state_store.sv
module cp_state_store
  import ctxprob_pkg::*;
#(
  parameter int NUM_CTX = 19,
  parameter int CTX_W   = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTX_W-1:0] rd_addr,
  output ctx_state_t       rd_data,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_addr,
  input  ctx_state_t       wr_data
);
  ctx_state_t mem [NUM_CTX];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CTX; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // a read of the entry being written this cycle sees the new value
  always_comb begin
    if (wr_en && wr_addr == rd_addr) rd_data = wr_data;
    else                             rd_data = mem[rd_addr];
  end
endmodule

// File: rtl/ctx_prob_estimator.sv
module ctx_prob_estimator
  import ctxprob_pkg::*;
#(
  parameter int NUM_CTX = 19,
  parameter int CTX_W   = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CTX_W-1:0] in_ctx,
  input  logic             in_dec,
  output logic             out_valid,
  output logic [5:0]       out_idx,
  output logic             out_mps,
  output logic [15:0]      out_qe,
  output logic [3:0]       out_lz
);
  localparam logic [CTX_W-1:0] LAST_CTX = CTX_W'(NUM_CTX - 1);

  logic             req_ok;
  logic [CTX_W-1:0] rd_addr;
  ctx_state_t       rd_state;
  prob_t            rd_prob;
  logic [CTX_W-1:0] wb_ctx;
  logic             wb_dec;
  ctx_state_t       wb_cur;
  ctx_state_t       wb_next;

  assign req_ok  = in_valid && (in_ctx <= LAST_CTX);
  assign rd_addr = req_ok ? in_ctx : '0;
  assign wb_cur  = '{idx: out_idx, mps: out_mps};

  cp_state_store #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_state),
    .wr_en   (out_valid),
    .wr_addr (wb_ctx),
    .wr_data (wb_next)
  );

  cp_prob_lookup u_lookup (
    .idx  (rd_state.idx),
    .prob (rd_prob)
  );

  cp_next_state u_next (
    .cur (wb_cur),
    .dec (wb_dec),
    .nxt (wb_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_mps   <= 1'b0;
      out_qe    <= '0;
      out_lz    <= '0;
      wb_ctx    <= '0;
      wb_dec    <= 1'b0;
    end else begin
      out_valid <= req_ok;
      if (req_ok) begin
        out_idx <= rd_state.idx;
        out_mps <= rd_state.mps;
        out_qe  <= rd_prob.qe;
        out_lz  <= rd_prob.lz;
        wb_ctx  <= in_ctx;
        wb_dec  <= in_dec;
      end
    end
  end
endmodule

// File: rtl/ctx_prob_estimator_chk.sv
module ctx_prob_estimator_chk #(
  parameter int NUM_CTX = 19,
  parameter int CTX_W   = $clog2(NUM_CTX)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [CTX_W-1:0] in_ctx,
  input logic             in_dec,
  input logic             out_valid,
  input logic [5:0]       out_idx,
  input logic             out_mps,
  input logic [15:0]      out_qe,
  input logic [3:0]       out_lz
);
  localparam int QW = 16;

  // R2 / R10: a result only follows an accepted request
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && int'($past(in_ctx)) < NUM_CTX));

  // R2: every accepted request produces a result
  assert_request_answered_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && int'($past(in_ctx)) < NUM_CTX) |-> out_valid);

  // R3: fixed outer bits of the probability
  assert_qe_format_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_qe[1:0] == 2'b01 && !out_qe[15]));

  // R4: leading-zero count agrees with the probability
  assert_lz_match_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((((out_qe << out_lz) & 16'h8000) != 16'h0000) &&
                   ((out_qe >> (QW - int'(out_lz))) == 16'h0000)));

  // R5 with R8: an MPS on the same context never lowers the index nor changes MPS
  assert_mps_monotone_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && $past(in_ctx) == $past(in_ctx, 2) &&
     $past(in_dec, 2) == $past(out_mps))
    |-> (out_idx >= $past(out_idx) && out_mps == $past(out_mps)));

  // R7 with R8: an LPS inverts MPS exactly at indices 0, 6, 14
  assert_lps_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && $past(in_ctx) == $past(in_ctx, 2) &&
     $past(in_dec, 2) != $past(out_mps))
    |-> (out_mps == ($past(out_mps) ^ ($past(out_idx) == 6'd0 ||
                                        $past(out_idx) == 6'd6 ||
                                        $past(out_idx) == 6'd14))));
endmodule

bind ctx_prob_estimator ctx_prob_estimator_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ctx    (in_ctx),
  .in_dec    (in_dec),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .out_mps   (out_mps),
  .out_qe    (out_qe),
  .out_lz    (out_lz)
);

// File: tb/test_ctx_prob_estimator.sv
`timescale 1ns/1ps
module test_ctx_prob_estimator;
  localparam int NCTX = 19;
  localparam int CW   = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_ctx = '0;
  logic          in_dec = 1'b0;
  logic          out_valid;
  logic [5:0]    out_idx;
  logic          out_mps;
  logic [15:0]   out_qe;
  logic [3:0]    out_lz;

  always #10 clk = ~clk;

  ctx_prob_estimator #(.NUM_CTX(NCTX), .CTX_W(CW)) i_ctx_prob_estimator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctx(in_ctx), .in_dec(in_dec),
    .out_valid(out_valid), .out_idx(out_idx), .out_mps(out_mps),
    .out_qe(out_qe), .out_lz(out_lz)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    m_idx [NCTX];
  bit    m_mps [NCTX];
  bit    pend_v = 0;
  int    pend_idx = 0;
  bit    pend_mps = 0;
  string pend_tag = "";
  logic [15:0] lfsr = 16'hace1;

  function automatic int qe_of(input int x);
    case (x)
      0: return 'h5601;  1: return 'h3401;  2: return 'h1801;  3: return 'h0ac1;
      4: return 'h0521;  5: return 'h0221;  6: return 'h5601;  7: return 'h5401;
      8: return 'h4801;  9: return 'h3801; 10: return 'h3001; 11: return 'h2401;
     12: return 'h1c01; 13: return 'h1601; 14: return 'h5601; 15: return 'h5401;
     16: return 'h5101; 17: return 'h4801; 18: return 'h3801; 19: return 'h3401;
     20: return 'h3001; 21: return 'h2801; 22: return 'h2401; 23: return 'h2201;
     24: return 'h1c01; 25: return 'h1801; 26: return 'h1601; 27: return 'h1401;
     28: return 'h1201; 29: return 'h1101; 30: return 'h0ac1; 31: return 'h09c1;
     32: return 'h08a1; 33: return 'h0521; 34: return 'h0441; 35: return 'h02a1;
     36: return 'h0221; 37: return 'h0141; 38: return 'h0111; 39: return 'h0085;
     40: return 'h0049; 41: return 'h0025; 42: return 'h0015; 43: return 'h0009;
     44: return 'h0005; 45: return 'h0001; default: return 'h5601;
    endcase
  endfunction

  function automatic int clz16(input int v);
    for (int b = 15; b >= 0; b--) if (v[b]) return 15 - b;
    return 16;
  endfunction

  // R5 rule
  function automatic int rule_mps(input int x);
    if (x == 5) return 38;
    if (x == 13) return 29;
    if (x >= 45) return x;
    return x + 1;
  endfunction

  // R6 rule
  function automatic int rule_lps(input int x);
    if (x == 0) return 1;
    if (x <= 3) return 3 * (x + 1);
    if (x == 4) return 29;
    if (x == 5) return 33;
    if (x == 6 || x == 46) return x;
    if (x <= 9) return 14;
    if (x <= 11) return x + 7;
    if (x <= 13) return x + 8;
    if (x <= 15) return 14;
    if (x <= 20) return x - 1;
    return x - 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_out();
    chk({"R2/R10 valid ", pend_tag}, int'(out_valid), int'(pend_v));
    if (pend_v) begin
      chk({"R5/R6 idx ", pend_tag}, int'(out_idx), pend_idx);
      chk({"R7 mps ", pend_tag}, int'(out_mps), int'(pend_mps));
      chk({"R3 qe ", pend_tag}, int'(out_qe), qe_of(pend_idx));
      chk({"R4 lz ", pend_tag}, int'(out_lz), clz16(qe_of(pend_idx)));
    end
  endtask

  task automatic step(input bit v, input int ctx, input bit d, input string tag);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_ctx   = CW'(ctx);
    in_dec   = d;
    pend_v   = v && ctx < NCTX;
    pend_tag = tag;
    if (pend_v) begin
      pend_idx = m_idx[ctx];
      pend_mps = m_mps[ctx];
      if (d == m_mps[ctx]) begin
        m_idx[ctx] = rule_mps(m_idx[ctx]);
      end else begin
        if (m_idx[ctx] == 0 || m_idx[ctx] == 6 || m_idx[ctx] == 14) m_mps[ctx] = !m_mps[ctx];
        m_idx[ctx] = rule_lps(m_idx[ctx]);
      end
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic rand_phase(input int n, input int lps_mod);
    for (int k = 0; k < n; k++) begin
      int c;
      bit v;
      bit lps;
      next_rand();
      c   = int'(lfsr[4:0]) % 24;
      v   = (lfsr[7:5] != 3'd0);
      lps = (int'(lfsr[15:8]) % lps_mod) == 0;
      step(v, c, (c < NCTX) ? (m_mps[c] ^ lps) : lfsr[9], "R9 random");
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCTX; i++) begin
      m_idx[i] = 0;
      m_mps[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    rst = 1'b0;

    // R1: fresh state on every context (MPS decision 0)
    for (int c = 0; c < NCTX; c++) step(1'b1, c, 1'b0, "R1 reset state");

    // R8: same-context bursts, MPS then LPS mixes, crossing switch indices
    for (int k = 0; k < 30; k++) step(1'b1, 3, m_mps[3] ^ (k % 4 == 3), "R8 burst");
    for (int k = 0; k < 30; k++) step(1'b1, 7, !m_mps[7], "R8 lps burst");
    for (int k = 0; k < 60; k++) step(1'b1, 11, m_mps[11] ^ (k % 9 == 8), "R8 walk");

    // R10: out-of-range labels and idle requests, then read back all contexts
    for (int c = NCTX; c < 32; c++) step(1'b1, c, 1'b1, "R10 out of range");
    for (int k = 0; k < 8; k++) step(1'b0, k, 1'b1, "R10 idle");
    for (int c = 0; c < NCTX; c++) step(1'b1, c, m_mps[c], "R10 readback");

    // R5 R6 R7 R9: long random streams with two LPS mixes
    rand_phase(12000, 8);
    rand_phase(6000, 2);

    // R9: final readback of every context
    for (int c = 0; c < NCTX; c++) step(1'b1, c, m_mps[c], "R9 readback");
    step(1'b0, 0, 1'b0, "R2 drain");
    step(1'b0, 0, 1'b0, "R2 drain");
    finish_run();
  end
endmodule